// File: doc/BRIEF.md
# Multi-Channel Countdown Timer with PWM Output

This block holds a set of identical down-counting timers, eight by default, behind a small memory-mapped register port. Software picks each timer's phase widths by writing two reload values. It sets a control word to start the timer, choose how the counter reloads, mask its interrupt and turn on the waveform output. Each timer counts down once per clock. When it reaches zero it reloads, raises an interrupt flag and, in waveform mode, flips its output pin. The two reload values take turns setting the low and the high phase, so every phase lasts at least one clock. A steady low or steady high output cannot be produced while the waveform is on.

Interrupt flags are cleared by a read with side effects. A read of a timer's own clear register clears that timer's flag, and a read of the shared clear register clears every flag. Status registers return the flags either raw or filtered by the per-timer masks. A single interrupt line is high while any unmasked flag is set.

Top module: `tmr_pwm_bank`

## Requirements
- R1: In waveform mode the low phase lasts (low reload + 1) clocks and the high phase lasts (high reload + 1) clocks. This holds for a reload of 0, which gives one clock.
- R2: Each time a timer is enabled, its counter takes the low reload value and the output begins with the low phase. Counting starts in the cycle after the enable is registered.
- R3: In each timer's control word, bit 0 enables the timer, bit 1 picks reload-from-register mode (1) or free-running mode (0), bit 2 masks the interrupt and bit 3 turns on waveform output. Bits above 3 read back as 0.
- R4: While a timer is disabled, its output is 0 and its counter value does not change.
- R5: When the counter reaches zero in reload-from-register mode, it reloads from the reload value of the phase that follows. In free-running mode it reloads with all ones.
- R6: A reload value written while the timer runs is used from the next reload on. The phase in progress is not cut short or stretched.
- R7: Each zero crossing sets that timer's raw flag. A read of the timer's own clear register (timer base + 0x0C) clears only that timer's flag. A flag that is set and cleared in the same cycle stays set.
- R8: A read of the shared clear register (0xA4) clears the raw flags of all timers.
- R9: Masked status is the raw flags with each masked timer's flag forced to 0. The interrupt output is high exactly while some masked-status bit is 1. The timer's own status register (base + 0x10) returns its masked bit in bit 0.
- R10: Timer n has its base at n*0x14. Its low reload is at base+0x00, its counter value at base+0x04 and its control word at base+0x08. Its high reload is at 0xB0+4*n. The shared registers are masked status at 0xA0, raw status at 0xA8 and a constant version word at 0xAC. All registers are 0 after reset, except the version word.
- R11: With waveform output off, the timer's output pin stays 0 while the timer counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all counting and register updates happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address for register access |
| bus_wdata | input | CNT_W | Write data |
| bus_we | input | 1 | Write strobe, one write per clock it is high |
| bus_re | input | 1 | Read strobe; a read of a clear register takes effect at the clock edge |
| bus_rdata | output | CNT_W | Read data for the register at bus_addr, valid in the same cycle |
| pwm_out | output | NUM_TIMERS | Waveform output, one bit per timer |
| irq | output | 1 | High while any unmasked interrupt flag is set |

## Verification
The assertions rely on the port being used in single-access cycles. The address must be stable while a strobe is high, and write and read strobes must not be raised together. The assertions also rely on a clear read being the only event, other than a zero crossing, that changes a flag. The bench meets these conditions because its tasks drive one access at a time, change inputs only on the falling edge and return the strobes low after the rising edge they target. Reload and control values are always written before the enable that uses them, apart from the live reload update that R6 targets.

// File: rtl/tmr_pwm_pkg.sv
package tmr_pwm_pkg;

    localparam int ADDR_W = 8;

    // control word bit positions
    localparam int CTL_W    = 4;
    localparam int CTL_EN   = 0;
    localparam int CTL_USER = 1;
    localparam int CTL_MASK = 2;
    localparam int CTL_PWM  = 3;

    // per-timer window
    localparam int CH_STRIDE = 'h14;
    localparam int OFS_LO    = 'h00;
    localparam int OFS_CUR   = 'h04;
    localparam int OFS_CTL   = 'h08;
    localparam int OFS_CLR   = 'h0C;
    localparam int OFS_STS   = 'h10;

    // shared registers
    localparam int GLB_STS   = 'hA0;
    localparam int GLB_CLR   = 'hA4;
    localparam int GLB_RAW   = 'hA8;
    localparam int GLB_VER   = 'hAC;
    localparam int HI_BASE   = 'hB0;
    localparam int HI_STRIDE = 4;

endpackage

// File: rtl/tmr_pwm_decode.sv
module tmr_pwm_decode
    import tmr_pwm_pkg::*;
#(
    parameter int NUM_TIMERS = 8
) (
    input  logic [ADDR_W-1:0]     addr,
    output logic [NUM_TIMERS-1:0] hit_lo,
    output logic [NUM_TIMERS-1:0] hit_hi,
    output logic [NUM_TIMERS-1:0] hit_cur,
    output logic [NUM_TIMERS-1:0] hit_ctl,
    output logic [NUM_TIMERS-1:0] hit_clr,
    output logic [NUM_TIMERS-1:0] hit_sts,
    output logic                  hit_gsts,
    output logic                  hit_gclr,
    output logic                  hit_graw,
    output logic                  hit_gver
);

    for (genvar n = 0; n < NUM_TIMERS; n++) begin : g_ch
        localparam int BASE = n * CH_STRIDE;
        assign hit_lo[n]  = (addr == ADDR_W'(BASE + OFS_LO));
        assign hit_cur[n] = (addr == ADDR_W'(BASE + OFS_CUR));
        assign hit_ctl[n] = (addr == ADDR_W'(BASE + OFS_CTL));
        assign hit_clr[n] = (addr == ADDR_W'(BASE + OFS_CLR));
        assign hit_sts[n] = (addr == ADDR_W'(BASE + OFS_STS));
        assign hit_hi[n]  = (addr == ADDR_W'(HI_BASE + n * HI_STRIDE));
    end

    assign hit_gsts = (addr == ADDR_W'(GLB_STS));
    assign hit_gclr = (addr == ADDR_W'(GLB_CLR));
    assign hit_graw = (addr == ADDR_W'(GLB_RAW));
    assign hit_gver = (addr == ADDR_W'(GLB_VER));

endmodule

// File: rtl/tmr_pwm_chan.sv
module tmr_pwm_chan #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             user_mode,
    input  logic             pwm_mode,
    input  logic [CNT_W-1:0] reload_lo,
    input  logic [CNT_W-1:0] reload_hi,
    output logic [CNT_W-1:0] cur,
    output logic             expire,
    output logic             wave
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             phase;   // 0 = low phase, 1 = high phase
        logic             run;     // counter has been loaded since enable
    } chan_t;

    chan_t st_d, st_q;
    logic  at_zero;

    assign at_zero = (st_q.cnt == '0);

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (!en) begin
            st_d.run   = 1'b0;
            st_d.phase = 1'b0;
        end else if (!st_q.run) begin
            st_d.run   = 1'b1;
            st_d.phase = 1'b0;
            st_d.cnt   = reload_lo;
        end else if (at_zero) begin
            expire = 1'b1;
            if (pwm_mode) begin
                st_d.phase = ~st_q.phase;
            end
            if (!user_mode) begin
                st_d.cnt = '1;
            end else if (pwm_mode && !st_q.phase) begin
                st_d.cnt = reload_hi;
            end else begin
                st_d.cnt = reload_lo;
            end
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur  = st_q.cnt;
    assign wave = st_q.run & en & pwm_mode & st_q.phase;

endmodule

// File: rtl/tmr_pwm_bank.sv
module tmr_pwm_bank
    import tmr_pwm_pkg::*;
#(
    parameter int          NUM_TIMERS = 8,
    parameter int          CNT_W      = 32,
    parameter logic [31:0] VERSION    = 32'h0001_0203
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [CNT_W-1:0]      bus_wdata,
    input  logic                  bus_we,
    input  logic                  bus_re,
    output logic [CNT_W-1:0]      bus_rdata,
    output logic [NUM_TIMERS-1:0] pwm_out,
    output logic                  irq
);

    typedef struct packed {
        logic [NUM_TIMERS-1:0][CNT_W-1:0] lo;
        logic [NUM_TIMERS-1:0][CNT_W-1:0] hi;
        logic [NUM_TIMERS-1:0][CTL_W-1:0] ctl;
        logic [NUM_TIMERS-1:0]            raw;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [NUM_TIMERS-1:0] hit_lo, hit_hi, hit_cur, hit_ctl, hit_clr, hit_sts;
    logic                  hit_gsts, hit_gclr, hit_graw, hit_gver;

    logic [NUM_TIMERS-1:0]            en_vec, user_vec, mask_vec, pwm_vec;
    logic [NUM_TIMERS-1:0]            expire_vec, raw_vec, masked_vec;
    logic [NUM_TIMERS-1:0][CNT_W-1:0] cur_vec;

    tmr_pwm_decode #(.NUM_TIMERS(NUM_TIMERS)) i_decode (
        .addr     (bus_addr),
        .hit_lo   (hit_lo),
        .hit_hi   (hit_hi),
        .hit_cur  (hit_cur),
        .hit_ctl  (hit_ctl),
        .hit_clr  (hit_clr),
        .hit_sts  (hit_sts),
        .hit_gsts (hit_gsts),
        .hit_gclr (hit_gclr),
        .hit_graw (hit_graw),
        .hit_gver (hit_gver)
    );

    for (genvar n = 0; n < NUM_TIMERS; n++) begin : g_ch
        assign en_vec[n]   = regs_q.ctl[n][CTL_EN];
        assign user_vec[n] = regs_q.ctl[n][CTL_USER];
        assign mask_vec[n] = regs_q.ctl[n][CTL_MASK];
        assign pwm_vec[n]  = regs_q.ctl[n][CTL_PWM];

        tmr_pwm_chan #(.CNT_W(CNT_W)) i_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (en_vec[n]),
            .user_mode (user_vec[n]),
            .pwm_mode  (pwm_vec[n]),
            .reload_lo (regs_q.lo[n]),
            .reload_hi (regs_q.hi[n]),
            .cur       (cur_vec[n]),
            .expire    (expire_vec[n]),
            .wave      (pwm_out[n])
        );
    end

    assign raw_vec    = regs_q.raw;
    assign masked_vec = regs_q.raw & ~mask_vec;
    assign irq        = |masked_vec;

    // register writes and flag update
    always_comb begin
        regs_d = regs_q;
        for (int n = 0; n < NUM_TIMERS; n++) begin
            if (bus_we && hit_lo[n]) begin
                regs_d.lo[n] = bus_wdata;
            end
            if (bus_we && hit_hi[n]) begin
                regs_d.hi[n] = bus_wdata;
            end
            if (bus_we && hit_ctl[n]) begin
                regs_d.ctl[n] = bus_wdata[CTL_W-1:0];
            end
            if (bus_re && (hit_clr[n] || hit_gclr)) begin
                regs_d.raw[n] = 1'b0;
            end
            if (expire_vec[n]) begin
                regs_d.raw[n] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        for (int n = 0; n < NUM_TIMERS; n++) begin
            if (hit_lo[n])  bus_rdata = regs_q.lo[n];
            if (hit_hi[n])  bus_rdata = regs_q.hi[n];
            if (hit_cur[n]) bus_rdata = cur_vec[n];
            if (hit_ctl[n]) bus_rdata = CNT_W'(regs_q.ctl[n]);
            if (hit_sts[n]) bus_rdata = CNT_W'(masked_vec[n]);
        end
        if (hit_gsts) bus_rdata = CNT_W'(masked_vec);
        if (hit_graw) bus_rdata = CNT_W'(raw_vec);
        if (hit_gver) bus_rdata = CNT_W'(VERSION);
    end

endmodule

// File: rtl/tmr_pwm_bank_chk.sv
module tmr_pwm_bank_chk
    import tmr_pwm_pkg::*;
#(
    parameter int NUM_TIMERS = 8,
    parameter int CNT_W      = 32
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [ADDR_W-1:0]               bus_addr,
    input logic                            bus_re,
    input logic [NUM_TIMERS-1:0]           en_vec,
    input logic [NUM_TIMERS-1:0]           pwm_vec,
    input logic [NUM_TIMERS-1:0]           expire_vec,
    input logic [NUM_TIMERS-1:0]           raw_vec,
    input logic [NUM_TIMERS-1:0][CNT_W-1:0] cur_vec,
    input logic [NUM_TIMERS-1:0]           pwm_out,
    input logic                            irq
);

    for (genvar n = 0; n < NUM_TIMERS; n++) begin : g_chk
        // R4: output low while disabled
        p_out_low_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !en_vec[n] |-> !pwm_out[n]);

        // R4: counter frozen once disabled
        p_cnt_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!en_vec[n]) |-> $stable(cur_vec[n]));

        // R11: no waveform without waveform mode
        p_no_wave_r11: assert property (@(posedge clk) disable iff (!rst_n)
            !pwm_vec[n] |-> !pwm_out[n]);

        // R7: zero crossing sets the raw flag
        p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
            expire_vec[n] |=> raw_vec[n]);
    end

    // R8: shared clear leaves only flags set in the same cycle
    p_all_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == ADDR_W'(GLB_CLR)) |=> ((raw_vec & ~$past(expire_vec)) == '0));

    // R9: no flags, no interrupt
    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_vec == '0) |-> !irq);

endmodule

bind tmr_pwm_bank tmr_pwm_bank_chk #(
    .NUM_TIMERS (NUM_TIMERS),
    .CNT_W      (CNT_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_re     (bus_re),
    .en_vec     (en_vec),
    .pwm_vec    (pwm_vec),
    .expire_vec (expire_vec),
    .raw_vec    (raw_vec),
    .cur_vec    (cur_vec),
    .pwm_out    (pwm_out),
    .irq        (irq)
);

// File: tb/test_tmr_pwm_bank.sv
module test_tmr_pwm_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [NT-1:0] pwm_out;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_pwm_bank i_tmr_pwm_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out),
        .irq       (irq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_re = 1'b0;
    endtask

    function automatic logic [7:0] base(input int ch);
        return 8'(ch * 'h14);
    endfunction

    // caller stands at a falling edge; counts samples at level lvl
    task automatic run_len(input int ch, input logic lvl, output int len);
        len = 0;
        while (pwm_out[ch] == lvl && len < 1000) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R10", "pwm_out after reset", 32'(pwm_out), 32'h0);
        chk("R9", "irq after reset", 32'(irq), 32'h0);
        rd(base(0) + 8'h04, v);
        chk("R10", "counter 0 after reset", v, 32'h0);
        rd(8'hA8, v);
        chk("R10", "raw status after reset", v, 32'h0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        wr(base(2), 32'h0000_1234);
        rd(base(2), v);
        chk("R10", "low reload timer 2", v, 32'h0000_1234);
        wr(8'hB0 + 8'd20, 32'hCAFE_0005);
        rd(8'hB0 + 8'd20, v);
        chk("R10", "high reload timer 5", v, 32'hCAFE_0005);
        wr(base(1) + 8'h08, 32'hFFFF_FFF6);
        rd(base(1) + 8'h08, v);
        chk("R3", "control word width", v, 32'h6);
        wr(base(1) + 8'h08, 32'h0);
        rd(8'hAC, v);
        chk("R10", "version word", v, 32'h0001_0203);
    endtask

    task automatic t_pwm(input int ch, input int lo, input int hi);
        int len;
        wr(base(ch), 32'(lo));
        wr(8'hB0 + 8'(4*ch), 32'(hi));
        wr(base(ch) + 8'h08, 32'hB);
        @(negedge clk);
        run_len(ch, 1'b0, len);
        chk("R2", $sformatf("first low samples ch%0d", ch), 32'(len), 32'(lo + 2));
        run_len(ch, 1'b1, len);
        chk("R1", $sformatf("high width ch%0d", ch), 32'(len), 32'(hi + 1));
        run_len(ch, 1'b0, len);
        chk("R1", $sformatf("low width ch%0d", ch), 32'(len), 32'(lo + 1));
        wr(base(ch) + 8'h08, 32'h0);
        @(negedge clk);
        chk("R4", $sformatf("output low when off ch%0d", ch), 32'(pwm_out[ch]), 32'h0);
    endtask

    task automatic t_live_reload();
        int len;
        wr(base(7), 32'd2);
        wr(8'hB0 + 8'd28, 32'd2);
        wr(base(7) + 8'h08, 32'hB);
        repeat (9) @(negedge clk);
        wr(8'hB0 + 8'd28, 32'd6);
        @(negedge clk);
        run_len(7, 1'b1, len);
        run_len(7, 1'b0, len);
        run_len(7, 1'b1, len);
        chk("R6", "high width after live update", 32'(len), 32'd7);
        wr(base(7) + 8'h08, 32'h0);
    endtask

    task automatic t_reload_modes();
        logic [31:0] v, v2;
        // reload-from-register, waveform off
        wr(base(0), 32'd4);
        wr(base(0) + 8'h08, 32'h3);
        repeat (6) @(negedge clk);
        chk("R11", "no waveform when mode off", 32'(pwm_out[0]), 32'h0);
        rd(base(0) + 8'h04, v);
        chk("R5", "user mode reload value", v, 32'd4);
        wr(base(0) + 8'h08, 32'h0);
        // free running
        wr(base(1), 32'd2);
        wr(base(1) + 8'h08, 32'h1);
        repeat (4) @(negedge clk);
        rd(base(1) + 8'h04, v);
        chk("R5", "free running reload value", v, 32'hFFFF_FFFF);
        wr(base(1) + 8'h08, 32'h0);
        rd(base(1) + 8'h04, v);
        repeat (5) @(negedge clk);
        rd(base(1) + 8'h04, v2);
        chk("R4", "counter frozen while off", v2, v);
        wr(8'hA4, 32'h0);
        rd(8'hA4, v);
    endtask

    task automatic t_flags();
        logic [31:0] v;
        wr(base(3), 32'd1);
        wr(base(4), 32'd1);
        wr(base(3) + 8'h08, 32'h3);
        wr(base(4) + 8'h08, 32'h3);
        repeat (6) @(negedge clk);
        chk("R9", "irq with unmasked flags", 32'(irq), 32'h1);
        wr(base(3) + 8'h08, 32'h2);
        wr(base(4) + 8'h08, 32'h2);
        rd(8'hA8, v);
        chk("R7", "raw flags of timers 3 and 4", v, 32'h18);
        rd(base(3) + 8'h10, v);
        chk("R9", "own status timer 3", v, 32'h1);
        rd(base(3) + 8'h0C, v);
        rd(8'hA8, v);
        chk("R7", "own clear touches only timer 3", v, 32'h10);
        rd(8'hA4, v);
        rd(8'hA8, v);
        chk("R8", "shared clear", v, 32'h0);
        @(negedge clk);
        chk("R8", "irq after shared clear", 32'(irq), 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(base(6), 32'd0);
        wr(base(6) + 8'h08, 32'h7);
        repeat (4) @(negedge clk);
        wr(base(6) + 8'h08, 32'h6);
        rd(8'hA8, v);
        chk("R9", "raw flag despite mask", v, 32'h40);
        rd(8'hA0, v);
        chk("R9", "masked status hidden", v, 32'h0);
        rd(base(6) + 8'h10, v);
        chk("R9", "own status hidden", v, 32'h0);
        chk("R9", "irq low when masked", 32'(irq), 32'h0);
        wr(base(6) + 8'h08, 32'h2);
        @(negedge clk);
        chk("R9", "irq after unmask", 32'(irq), 32'h1);
        rd(8'hA0, v);
        chk("R9", "masked status after unmask", v, 32'h40);
        rd(8'hA4, v);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_pwm(0, 0, 0);
        t_pwm(2, 3, 5);
        t_pwm(5, 7, 1);
        t_pwm(2, 3, 5);
        t_live_reload();
        t_reload_modes();
        t_flags();
        t_mask();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule